// File: doc/BRIEF.md
# Critical-Chunk-First Line Fill Sequencer

This block loads one cache line from a memory bus that is narrower than the line, one beat per accepted bus transfer. On a miss it is given the missing address, and it asks memory first for the chunk that holds the requested word. It then walks the remaining chunks in ascending order and wraps past the top of the line back to chunk zero, until every chunk of the line has been written.

Each accepted beat drives a one-hot write enable and the beat data toward the line storage. The first beat carries the requested word, so the block hands that word back to the waiting requester one cycle later. The cache can therefore unblock while the other chunks are still streaming in. A per-chunk arrival map answers lookups into the line being filled. An access to a chunk that has already arrived is a hit. An access to a chunk that has not arrived yet must stall.

Top module: `crit_fill`

## Requirements
- R1: After reset, busy_o, crit_valid_o, fill_done_o, lookup_hit_o and lookup_stall_o are 0, and line_we_o is all zeros.
- R2: A request taken while idle makes busy_o 1 on the next cycle. The first mem_addr_o is the line base plus the chunk that holds the requested address. Chunk index = address bits [5:2]; mem_addr_o = {line tag, chunk index, 2'b00}.
- R3: Each accepted beat (mem_valid_i high while busy) advances the chunk index by one modulo 16, so the order wraps from 15 to 0. During a beat, line_we_o is one-hot with bit c set, where c is the chunk named by mem_addr_o, and line_wdata_o equals mem_data_i.
- R4: In the cycle after the first accepted beat of a fill, crit_valid_o is 1 for exactly one cycle. crit_data_o equals that beat's data and holds it until the next fill's first beat.
- R5: fill_done_o is 1 combinationally during the 16th accepted beat and at no other time. busy_o is 0 on the cycle after that beat.
- R6: While busy, a cycle with mem_valid_i low writes nothing (line_we_o zero) and leaves mem_addr_o unchanged.
- R7: A request presented while busy is ignored. The chunk order and line address of the fill in progress continue unchanged.
- R8: While busy, a lookup whose line matches the filling line and whose chunk has already been accepted gives lookup_hit_o = 1. A chunk becomes visible from the cycle after its beat is accepted.
- R9: While busy, a lookup into the filling line at a chunk not yet accepted gives lookup_stall_o = 1 and lookup_hit_o = 0. A lookup into a different line, or any lookup while idle, gives both 0.
- R10: Beats offered while idle are ignored. line_we_o stays zero, fill_done_o stays 0, and no critical word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start a fill for req_addr_i (taken only when idle) |
| req_addr_i | input | 32 | Missing byte address |
| busy_o | output | 1 | Fill in progress |
| mem_addr_o | output | 32 | Address of the chunk expected on the next beat |
| mem_valid_i | input | 1 | Memory beat present |
| mem_data_i | input | 32 | Memory beat data |
| line_we_o | output | 16 | One-hot chunk write enable into line storage |
| line_wdata_o | output | 32 | Chunk write data |
| crit_valid_o | output | 1 | One-cycle pulse: requested word available |
| crit_data_o | output | 32 | Requested word |
| fill_done_o | output | 1 | High during the last beat of the fill |
| lookup_addr_i | input | 32 | Address of a concurrent access to test against the fill |
| lookup_hit_o | output | 1 | Access may be served from an arrived chunk |
| lookup_stall_o | output | 1 | Access targets a chunk still in flight |

## Verification
The assertions check the rules that hold on every cycle: write enables are never more than one-hot, the critical pulse never lasts two cycles, the block always leaves busy after fill_done_o, hit and stall are never both set, the first chunk index follows the request, and accepted beats move the index. Only the bench's scenarios can show the full wrapped order from various starting chunks and the exact data values. They also show beat gaps, requests dropped during a fill, the timing of chunk visibility for lookups, and beats ignored while idle.

// File: rtl/crit_fill_pkg.sv
package crit_fill_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;
endpackage

// File: rtl/crit_fill_order.sv
module crit_fill_order #(
  parameter int BEATS = 16,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             first_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      idx_q <= start_idx_i;
      cnt_q <= '0;
    end else if (step_i) begin
      // wrap order: next chunk modulo the chunk count
      idx_q <= (idx_q == IDX_W'(BEATS-1)) ? '0 : idx_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idx_o   = idx_q;
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == IDX_W'(BEATS-1));

  assert_start_idx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> idx_o == $past(start_idx_i));
  assert_step_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i) |=> idx_o != $past(idx_o));
endmodule

// File: rtl/crit_fill_track.sv
module crit_fill_track #(
  parameter int BEATS = 16,
  parameter int TAG_W = 26,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             busy_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  logic [TAG_W-1:0] look_tag_i,
  input  logic [IDX_W-1:0] look_idx_i,
  output logic             hit_o,
  output logic             stall_o
);
  logic [BEATS-1:0] arrived_q;
  logic             same_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      arrived_q <= '0;
    else if (clear_i) arrived_q <= '0;
    else if (set_i)   arrived_q[set_idx_i] <= 1'b1;
  end

  assign same_line = busy_i && (look_tag_i == line_tag_i);
  assign hit_o     = same_line &&  arrived_q[look_idx_i];
  assign stall_o   = same_line && !arrived_q[look_idx_i];

  assert_hit_stall_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && stall_o));
  assert_idle_no_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !(hit_o || stall_o));
endmodule

// File: rtl/crit_fill.sv
module crit_fill #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int BUS_BYTES  = 4,
  localparam int BUS_W  = 8 * BUS_BYTES,
  localparam int BEATS  = LINE_BYTES / BUS_BYTES,
  localparam int IDX_W  = $clog2(BEATS),
  localparam int BOFF_W = $clog2(BUS_BYTES),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [BUS_W-1:0]  mem_data_i,
  output logic [BEATS-1:0]  line_we_o,
  output logic [BUS_W-1:0]  line_wdata_o,
  output logic              crit_valid_o,
  output logic [BUS_W-1:0]  crit_data_o,
  output logic              fill_done_o,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              lookup_hit_o,
  output logic              lookup_stall_o
);
  import crit_fill_pkg::*;

  fill_state_e      state_q;
  logic [TAG_W-1:0] tag_q;
  logic             start, beat, first, last;
  logic [IDX_W-1:0] idx;
  logic             crit_v_q;
  logic [BUS_W-1:0] crit_d_q;

  assign busy_o = (state_q == FILL_RUN);
  assign start  = !busy_o && req_valid_i;
  assign beat   = busy_o && mem_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FILL_IDLE;
      tag_q   <= '0;
    end else if (start) begin
      state_q <= FILL_RUN;
      tag_q   <= req_addr_i[ADDR_W-1:OFF_W];
    end else if (beat && last) begin
      state_q <= FILL_IDLE;
    end
  end

  crit_fill_order #(.BEATS(BEATS)) u_order (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_idx_i (req_addr_i[OFF_W-1:BOFF_W]),
    .step_i      (beat),
    .idx_o       (idx),
    .first_o     (first),
    .last_o      (last)
  );

  crit_fill_track #(.BEATS(BEATS), .TAG_W(TAG_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start),
    .set_i      (beat),
    .set_idx_i  (idx),
    .busy_i     (busy_o),
    .line_tag_i (tag_q),
    .look_tag_i (lookup_addr_i[ADDR_W-1:OFF_W]),
    .look_idx_i (lookup_addr_i[OFF_W-1:BOFF_W]),
    .hit_o      (lookup_hit_o),
    .stall_o    (lookup_stall_o)
  );

  // requested word released one cycle after the first beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_v_q <= 1'b0;
      crit_d_q <= '0;
    end else begin
      crit_v_q <= beat && first;
      if (beat && first) crit_d_q <= mem_data_i;
    end
  end

  assign crit_valid_o = crit_v_q;
  assign crit_data_o  = crit_d_q;
  assign mem_addr_o   = {tag_q, idx, {BOFF_W{1'b0}}};
  assign line_we_o    = beat ? (BEATS'(1) << idx) : '0;
  assign line_wdata_o = mem_data_i;
  assign fill_done_o  = beat && last;

  assert_we_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_we_o));
  assert_crit_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_valid_o |=> !crit_valid_o);
  assert_done_leaves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |=> !busy_o);
  assert_busy_req_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fill_done_o) |=> (busy_o && $stable(mem_addr_o[ADDR_W-1:OFF_W])));
  assert_idle_no_we_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (line_we_o == '0 && !fill_done_o));
endmodule

// File: tb/crit_fill_tb_top.sv
module crit_fill_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        busy;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data = '0;
  logic [15:0] line_we;
  logic [31:0] line_wdata;
  logic        crit_valid;
  logic [31:0] crit_data;
  logic        fill_done;
  logic [31:0] lookup_addr = '0;
  logic        lookup_hit, lookup_stall;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crit_fill dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .busy_o(busy),
    .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_data_i(mem_data),
    .line_we_o(line_we), .line_wdata_o(line_wdata),
    .crit_valid_o(crit_valid), .crit_data_o(crit_data),
    .fill_done_o(fill_done), .lookup_addr_i(lookup_addr),
    .lookup_hit_o(lookup_hit), .lookup_stall_o(lookup_stall)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] chunk_addr(input logic [31:0] a, input int c);
    return {a[31:6], 4'(c), 2'b00};
  endfunction

  task automatic t_reset();
    #1;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(line_we == 0, "R1 we", line_we, 0);
    chk(crit_valid == 0 && fill_done == 0, "R1 crit/done", {crit_valid, fill_done}, 0);
    chk(lookup_hit == 0 && lookup_stall == 0, "R1 lookup", {lookup_hit, lookup_stall}, 0);
  endtask

  // one full fill; gaps inserts idle bus cycles, busy_req presents a second request mid-fill
  task automatic t_fill(input logic [31:0] addr, input bit gaps, input bit busy_req);
    int start_c;
    logic [31:0] d0;
    start_c = int'(addr[5:2]);
    @(negedge clk);
    req_valid = 1; req_addr = addr;
    @(negedge clk);
    req_valid = 0;
    #1;
    chk(busy == 1, "R2 busy after request", busy, 1);
    chk(mem_addr == chunk_addr(addr, start_c), "R2 first chunk address", mem_addr, chunk_addr(addr, start_c));
    for (int k = 0; k < NB; k++) begin
      int c;
      logic [31:0] d;
      c = (start_c + k) % NB;
      d = 32'hC0DE0000 ^ (addr << 3) ^ 32'(k * 257);
      if (k == 0) d0 = d;
      if (gaps && (k % 5 == 2)) begin
        mem_valid = 0;
        #1;
        chk(line_we == 0, "R6 no write in gap", line_we, 0);
        @(negedge clk);
        #1;
        chk(mem_addr == chunk_addr(addr, c), "R6 address held in gap", mem_addr, chunk_addr(addr, c));
      end
      mem_valid = 1; mem_data = d;
      if (busy_req && k == 4) begin
        req_valid = 1; req_addr = addr ^ 32'h0001_0024;
      end
      #1;
      chk(mem_addr == chunk_addr(addr, c), "R3 wrap order address", mem_addr, chunk_addr(addr, c));
      chk(line_we == (16'h1 << c), "R3 one-hot enable", line_we, 16'h1 << c);
      chk(line_wdata == d, "R3 write data", line_wdata, d);
      chk(fill_done == (k == NB-1), "R5 done on last beat only", fill_done, k == NB-1);
      @(negedge clk);
      mem_valid = 0; req_valid = 0;
      lookup_addr = chunk_addr(addr, start_c) | 32'h2;
      #1;
      chk(crit_valid == (k == 0), "R4 critical pulse", crit_valid, k == 0);
      if (busy_req && k == 4)
        chk(busy == 1, "R7 request while busy ignored", busy, 1);
      if (k < NB-1) begin
        chk(lookup_hit == 1 && lookup_stall == 0, "R8 arrived chunk hits", {lookup_hit, lookup_stall}, 2'b10);
        lookup_addr = chunk_addr(addr, (c + 1) % NB);
        #1;
        chk(lookup_stall == 1 && lookup_hit == 0, "R9 pending chunk stalls", {lookup_hit, lookup_stall}, 2'b01);
        if (k == 3) begin
          lookup_addr = addr ^ 32'h0000_0400;
          #1;
          chk(lookup_stall == 0 && lookup_hit == 0, "R9 other line neither", {lookup_hit, lookup_stall}, 0);
        end
      end else begin
        chk(busy == 0, "R5 idle after done", busy, 0);
        chk(lookup_hit == 0 && lookup_stall == 0, "R9 idle lookup neither", {lookup_hit, lookup_stall}, 0);
      end
      chk(crit_data == d0, "R4 critical data held", crit_data, d0);
    end
  endtask

  task automatic t_idle_beats();
    logic [31:0] prev;
    prev = crit_data;
    @(negedge clk);
    mem_valid = 1; mem_data = 32'hDEAD_BEEF;
    #1;
    chk(line_we == 0, "R10 idle beat no write", line_we, 0);
    chk(fill_done == 0, "R10 idle beat no done", fill_done, 0);
    @(negedge clk);
    mem_valid = 0;
    #1;
    chk(crit_valid == 0 && crit_data == prev, "R10 idle beat no critical word", crit_data, prev);
    chk(busy == 0, "R10 still idle", busy, 0);
  endtask

  initial begin
    t_reset();
    #(3*CLK_PERIOD);
    @(negedge clk);
    rst_n = 1;
    t_fill(32'h1234_5678, 0, 0);   // start chunk 14, wraps after two beats
    t_fill(32'h0000_1000, 1, 0);   // start chunk 0, with gaps
    t_fill(32'hABCD_EF3C, 0, 1);   // start chunk 15, request while busy
    t_idle_beats();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20000*CLK_PERIOD);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule